// File: doc/BRIEF.md
# Triple Timer Counter

This peripheral holds three independent 16-bit up-counters that share one input clock. Each counter has a power-of-two prescaler. It can run free and wrap around, or it can run in interval mode. In interval mode it restarts from zero after reaching a programmed limit and raises a sticky event flag. The flag drives that timer's interrupt line when its enable bit is set.

Software reaches the registers over a simple bus with a write strobe, a byte address and write data. Reads are combinational on the address. The six registers of each timer are grouped by kind: the registers of the same kind for timers 0, 1 and 2 sit at consecutive word addresses. The group base is the group index times 12 bytes:

| Group | Base | Contents |
|-------|------|----------|
| 0 | 0x00 | clock control |
| 1 | 0x0C | counter control |
| 2 | 0x18 | count value |
| 3 | 0x24 | interval |
| 4 | 0x30 | status |
| 5 | 0x3C | enable |

An asynchronous active-low reset is released synchronously inside the block.

Top module: `triple_timer`

## Requirements
- R1: After reset, every counter control register reads 0x0001 (stopped). All other registers read 0 and every interrupt output is low.
- R2: While counter control bit 0 is 1 the count holds its value. While it is 0 the count advances on every prescaled tick.
- R3: Writing counter control with bit 4 set clears the count and the prescaler phase in that write's cycle, whether or not the counter is stopped. Bit 4 always reads back 0.
- R4: With counter control bit 1 clear, the count increments once per tick and wraps from 0xFFFF to 0 without setting status bit 0.
- R5: Clock control bit 0 enables the prescaler and bits [4:1] hold N. When enabled, the count advances once every 2^(N+1) clocks: N=1 divides by 4 and N=4 divides by 32. When disabled, it advances every clock.
- R6: With counter control bit 1 set, the count runs 0 up to the interval value. On the next tick it returns to 0 and sets status bit 0, so the period is interval+1 ticks.
- R7: Status bit 0 is sticky. Writing the status register with bit 0 set clears it, and writing 0 leaves it unchanged.
- R8: Interrupt output i is high exactly when timer i has status bit 0 and enable bit 0 both set.
- R9: Timer i's register of group g is at byte address 12*g + 4*i. Timers do not disturb each other, and unmapped addresses read 0.
- R10: Counter control bits 0, 1 and 5, the clock control field and the interval value read back as written. Writes to the count value register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 3 | One interrupt line per timer |

## Verification
The bench uses the default parameters: three timers, a 16-bit count and a 4-bit prescale exponent. A 16-bit count makes a full free-running wrap reachable in about 65 thousand clocks with the prescaler bypassed, so the 0xFFFF to 0 roll is observed directly. The 4-bit exponent covers the divide-by-4 and divide-by-32 settings, and each is checked on the exact tick boundary. An interval of 5 exposes two complete periods, the acknowledge and the enable gating within a few dozen cycles.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  // register groups; address = group * (4 * timers) + 4 * timer
  localparam int NGRP    = 6;
  localparam int G_CLK   = 0;
  localparam int G_CTL   = 1;
  localparam int G_COUNT = 2;
  localparam int G_IVL   = 3;
  localparam int G_STS   = 4;
  localparam int G_IEN   = 5;
  // counter control bit positions
  localparam int CTL_STOP = 0;
  localparam int CTL_IVL  = 1;
  localparam int CTL_RST  = 4;
  localparam int CTL_WAVE = 5;
endpackage

// File: rtl/ttc_prescaler.sv
module ttc_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int DIV_W = 1 << PRE_W;

  logic [DIV_W-1:0] div_q, div_d, lim;
  logic             at_lim;

  always_comb begin
    for (int b = 0; b < DIV_W; b++) lim[b] = (PRE_W'(b) <= exp_i);
  end

  assign at_lim = (div_q >= lim);
  assign tick_o = run_i & (~pre_en_i | at_lim);

  always_comb begin
    div_d = div_q;
    if (clear_i)                div_d = '0;
    else if (run_i && pre_en_i) div_d = at_lim ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // with the prescaler on, two ticks can never be adjacent
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_o) && $past(pre_en_i) && !$past(clear_i) && pre_en_i) |-> !tick_o);
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_clk_i,
  input  logic                       wr_ctl_i,
  input  logic                       wr_ivl_i,
  input  logic                       wr_sts_i,
  input  logic                       wr_ien_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [NGRP-1:0][CNT_W-1:0] regs_o,
  output logic                       irq_o
);
  logic             stop_q, imode_q, wave_q, pre_en_q, sts_q, ien_q;
  logic [PRE_W-1:0] exp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, ivl_q;
  logic             sts_d, evt, tick, rst_cmd, ack;

  assign rst_cmd = wr_ctl_i & wdata_i[CTL_RST];
  assign ack     = wr_sts_i & wdata_i[0];

  ttc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (~stop_q),
    .clear_i  (rst_cmd),
    .pre_en_i (pre_en_q),
    .exp_i    (exp_q),
    .tick_o   (tick)
  );

  // next state of count and event flag
  always_comb begin
    cnt_d = cnt_q;
    evt   = 1'b0;
    if (rst_cmd) begin
      cnt_d = '0;
    end else if (tick) begin
      if (imode_q && (cnt_q >= ivl_q)) begin
        cnt_d = '0;
        evt   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    sts_d = (sts_q & ~ack) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b1;
      imode_q  <= 1'b0;
      wave_q   <= 1'b0;
      pre_en_q <= 1'b0;
      exp_q    <= '0;
      ivl_q    <= '0;
      ien_q    <= 1'b0;
    end else begin
      if (wr_ctl_i) begin
        stop_q  <= wdata_i[CTL_STOP];
        imode_q <= wdata_i[CTL_IVL];
        wave_q  <= wdata_i[CTL_WAVE];
      end
      if (wr_clk_i) begin
        pre_en_q <= wdata_i[0];
        exp_q    <= wdata_i[PRE_W:1];
      end
      if (wr_ivl_i) ivl_q <= wdata_i;
      if (wr_ien_i) ien_q <= wdata_i[0];
    end
  end

  always_comb begin
    regs_o          = '0;
    regs_o[G_CLK]   = CNT_W'({exp_q, pre_en_q});
    regs_o[G_CTL]   = CNT_W'({wave_q, 3'b000, imode_q, stop_q});
    regs_o[G_COUNT] = cnt_q;
    regs_o[G_IVL]   = ivl_q;
    regs_o[G_STS]   = CNT_W'(sts_q);
    regs_o[G_IEN]   = CNT_W'(ien_q);
  end

  assign irq_o = sts_q & ien_q;

  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_q) && !$past(rst_cmd)) |-> $stable(cnt_q));

  assert_rst_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_cmd) |-> (cnt_q == '0));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(imode_q) && !$past(rst_cmd) && ($past(cnt_q) == '1))
      |-> ((cnt_q == '0) && !$rose(sts_q)));

  assert_evt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> (cnt_q == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_q) && !$past(ack)) |-> sts_q);
endmodule

// File: rtl/triple_timer.sv
module triple_timer
  import ttc_pkg::*;
#(
  parameter int NUM_T  = 3,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_T-1:0]  irq
);
  localparam int GRP_STRIDE = 4 * NUM_T;

  function automatic logic [ADDR_W-1:0] reg_addr(input int g, input int t);
    return ADDR_W'(g * GRP_STRIDE + 4 * t);
  endfunction

  // reset: asserted at once, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NGRP-1:0][CNT_W-1:0] regs [NUM_T];

  for (genvar t = 0; t < NUM_T; t++) begin : g_tmr
    logic wr_clk, wr_ctl, wr_ivl, wr_sts, wr_ien;
    assign wr_clk = bus_wr && (bus_addr == reg_addr(G_CLK, t));
    assign wr_ctl = bus_wr && (bus_addr == reg_addr(G_CTL, t));
    assign wr_ivl = bus_wr && (bus_addr == reg_addr(G_IVL, t));
    assign wr_sts = bus_wr && (bus_addr == reg_addr(G_STS, t));
    assign wr_ien = bus_wr && (bus_addr == reg_addr(G_IEN, t));

    ttc_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_clk_i (wr_clk),
      .wr_ctl_i (wr_ctl),
      .wr_ivl_i (wr_ivl),
      .wr_sts_i (wr_sts),
      .wr_ien_i (wr_ien),
      .wdata_i  (bus_wdata),
      .regs_o   (regs[t]),
      .irq_o    (irq[t])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_T; t++)
      for (int g = 0; g < NGRP; g++)
        if (bus_addr == reg_addr(g, t)) bus_rdata = regs[t][g];
  end
endmodule

// File: tb/triple_timer_test.sv
module triple_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_q[$];
  int    kind_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  triple_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] ra(input int g, input int t);
    return 8'(g * 12 + 4 * t);
  endfunction

  // all tasks start and end on a falling edge
  task automatic wr(input int g, input int t, input int d);
    bus_addr = ra(g, t); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int e, input string tag);
    bus_addr = a;
    exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic irqchk(input int e, input string tag);
    exp_q.push_back(e); kind_q.push_back(1); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each queued item in the low phase of its cycle
  always begin
    @(negedge clk);
    #2;
    if (exp_q.size() > 0) begin
      int e, k, act;
      string tag;
      e = exp_q.pop_front(); k = kind_q.pop_front(); tag = tag_q.pop_front();
      act = (k == 0) ? int'(bus_rdata) : int'(irq);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, e);
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state of every timer
    for (int t = 0; t < 3; t++) begin
      rd(ra(0, t), 0, "R1 clk ctrl");
      rd(ra(1, t), 1, "R1 cnt ctrl");
      rd(ra(2, t), 0, "R1 count");
      rd(ra(3, t), 0, "R1 interval");
      rd(ra(4, t), 0, "R1 status");
      rd(ra(5, t), 0, "R1 enable");
    end
    irqchk(0, "R1 irq");
    idle(20);
    rd(ra(2, 1), 0, "R2 stopped count holds");

    // timer0 free run, divide by 1: read at N(m) after write sees m-1
    wr(1, 0, 16'h0010);
    rd(ra(2, 0), 0, "R3 count cleared on start");
    idle(65534);
    rd(ra(2, 0), 16'hFFFF, "R4 count at top");
    rd(ra(2, 0), 0, "R4 wrap to zero");
    rd(ra(4, 0), 0, "R4 no status on wrap");
    irqchk(0, "R4 no irq on wrap");
    wr(1, 0, 16'h0011);
    rd(ra(2, 0), 0, "R3 reset while stopping");
    idle(5);
    rd(ra(2, 0), 0, "R2 stopped after reset");
    rd(ra(1, 0), 1, "R3 reset bit self clears");

    // timer1 divide by 4
    wr(0, 1, 16'h0003);
    wr(1, 1, 16'h0010);
    rd(ra(2, 1), 0, "R5 div4 start");
    idle(7);
    rd(ra(2, 1), 2, "R5 div4 after 8 clocks");
    idle(3);
    rd(ra(2, 1), 3, "R5 div4 after 12 clocks");
    rd(ra(0, 1), 3, "R10 clk ctrl readback");

    // timer1 divide by 32
    wr(1, 1, 16'h0011);
    wr(0, 1, 16'h0009);
    wr(1, 1, 16'h0010);
    idle(31);
    rd(ra(2, 1), 0, "R5 div32 before tick");
    rd(ra(2, 1), 1, "R5 div32 first tick");
    wr(1, 1, 16'h0011);

    // timer2 interval 5, period 6
    wr(3, 2, 5);
    wr(5, 2, 1);
    wr(1, 2, 16'h0012);
    rd(ra(2, 2), 0, "R6 interval start");
    idle(4);
    rd(ra(2, 2), 5, "R6 reaches interval");
    rd(ra(4, 2), 1, "R6 event flagged");
    irqchk(3'b100, "R8 irq raised");
    wr(4, 2, 1);
    rd(ra(4, 2), 0, "R7 write one clears");
    irqchk(0, "R8 irq dropped");
    rd(ra(2, 2), 5, "R6 second period top");
    rd(ra(4, 2), 1, "R6 periodic event");
    wr(5, 2, 0);
    irqchk(0, "R8 enable gates irq");
    rd(ra(4, 2), 1, "R7 sticky with enable off");
    wr(4, 2, 0);
    rd(ra(4, 2), 1, "R7 write zero keeps");
    rd(ra(3, 2), 5, "R10 interval readback");

    // timer0 control bits and read-only count
    wr(1, 0, 16'h0033);
    rd(ra(1, 0), 16'h0023, "R10 ctrl bits readback");
    rd(ra(2, 0), 0, "R3 count zero after reset bit");
    wr(2, 0, 16'h1234);
    rd(ra(2, 0), 0, "R10 count write ignored");

    // address map
    wr(3, 1, 16'hABCD);
    rd(ra(3, 1), 16'hABCD, "R9 timer1 interval");
    rd(ra(3, 0), 0, "R9 timer0 interval untouched");
    rd(ra(3, 2), 5, "R9 timer2 interval untouched");
    rd(8'h48, 0, "R9 unmapped reads zero");

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule